// File: doc/BRIEF.md
# Dual Timer Bus Wrapper with Test Override

This block puts two countdown timer channels behind a single APB slave that occupies a 4 KB address window. The low part of the window holds two identical register banks, one per channel, chosen by address bit 5. Each channel raises its own interrupt. The wrapper also drives a third interrupt that is high whenever either channel interrupt is high.

For board-level and integration testing, a test-control register lets software take over both interrupt outputs. While test mode is on, the outputs follow a test-drive register instead of the channels. The top of the window holds twelve read-only identification bytes. Every access completes in one access phase with no wait states. Each channel holds a 32-bit down-counter with load, background-load, control, raw-status, masked-status and clear registers.

Top module: `dual_timer_apb`

## Requirements
- R1: Channel banks occupy offsets 0x000-0x03F. Address bit 5 picks the channel (0 = channel 0, 1 = channel 1). Bits 4:2 pick the register: 0 LOAD, 1 VALUE, 2 CONTROL, 3 INTCLR, 4 RIS, 5 MIS, 6 BGLOAD. Both LOAD and BGLOAD read back the reload value.
- R2: The test-control register at 0xF00 stores bit 0 only, reads it back in bit 0 with zeros above, and resets to 0.
- R3: The test-drive register at 0xF04 stores bits 1:0 and ignores higher bits. It is write-only and reads as zero. It resets to 0.
- R4: While test-control bit 0 is 1, irqCh[0] equals test-drive bit 0 and irqCh[1] equals test-drive bit 1. While it is 0, each irqCh bit is that channel's masked status, and the test-drive bits have no effect.
- R5: irqAny is the OR of the two irqCh bits.
- R6: The words at 0xFD0 through 0xFFC read, in ascending address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R7: Reads of any other offset return zero, and writes to them change nothing. This includes bank slot 7 (0x01C, 0x03C), offsets 0x040 and above below 0xF00, 0xF08, and 0xFCC.
- R8: pready is always 1 and pslverr always 0. A write takes effect only in the access phase (psel, penable and pwrite all high). A setup-phase-only write changes nothing.
- R9: After reset each channel reads CONTROL = 0x20, VALUE = 0xFFFFFFFF, LOAD = 0 and RIS = 0.
- R10: A LOAD write sets both the reload value and the counter. A BGLOAD write sets only the reload value. CONTROL keeps only bit 7 (enable), bit 6 (periodic), bit 5 (interrupt enable) and bit 0 (one-shot), so it reads back masked with 0xE1.
- R11: While enabled, the counter decrements once per clock, and the step from 1 to 0 sets RIS. At zero, a one-shot channel holds at zero. A periodic channel reloads the reload value, and a free-running channel reloads 0xFFFFFFFF.
- R12: MIS is RIS AND the interrupt-enable bit. Any write to INTCLR clears RIS, whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from the decoded register |
| pready | output | 1 | Tied high |
| pslverr | output | 1 | Tied low |
| irqCh | output | 2 | Per-channel interrupt outputs |
| irqAny | output | 1 | Combined interrupt |

## Verification
The assertions assume the bus follows the APB phase order: a setup cycle with penable low comes before each access cycle, and paddr and pwdata hold steady across both cycles. The write-capture properties sample the register one cycle after the access edge on that basis. The bench issues every transfer through one read task and one write task that hold address and data for both phases. Its single deliberately malformed cycle, a setup without an access, drops psel straight away and never raises penable.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int WORD_W   = ADDR_W - 2;
  localparam int CH_COUNT = 2;
  localparam int ID_COUNT = 12;
  localparam int ID_IDX_W = $clog2(ID_COUNT + 4);
  localparam int CTL_W    = 8;

  // control field positions
  localparam int CTL_ONE = 0;
  localparam int CTL_IEN = 5;
  localparam int CTL_PER = 6;
  localparam int CTL_EN  = 7;
  localparam logic [CTL_W-1:0] CTL_MASK  = 8'hE1;
  localparam logic [CTL_W-1:0] CTL_RESET = 8'h20;

  // word addresses of the upper registers
  localparam logic [WORD_W-1:0] TCTL_WORD     = 10'h3C0;
  localparam logic [WORD_W-1:0] TDRV_WORD     = 10'h3C1;
  localparam logic [WORD_W-1:0] ID_FIRST_WORD = 10'h3F4;

  typedef enum logic [2:0] {
    REG_LOAD = 3'd0, REG_VALUE = 3'd1, REG_CTRL = 3'd2, REG_ICLR = 3'd3,
    REG_RAW  = 3'd4, REG_MSK   = 3'd5, REG_BGLD = 3'd6, REG_NONE = 3'd7
  } bank_reg_e;

  typedef enum logic [1:0] {RD_NONE, RD_CHAN, RD_TCTL, RD_ID} rd_src_e;

  typedef struct packed {
    logic                chanWr;
    logic                chanIdx;
    bank_reg_e           bankReg;
    logic                tctlWr;
    logic                tdrvWr;
    rd_src_e             rdSrc;
    logic [ID_IDX_W-1:0] idIdx;
  } strobe_t;

  function automatic logic [7:0] idByte(input logic [ID_IDX_W-1:0] idx);
    case (idx)
      4'd0:  idByte = 8'h04;
      4'd4:  idByte = 8'h23;
      4'd5:  idByte = 8'hB8;
      4'd6:  idByte = 8'h1B;
      4'd8:  idByte = 8'h0D;
      4'd9:  idByte = 8'hF0;
      4'd10: idByte = 8'h05;
      4'd11: idByte = 8'hB1;
      default: idByte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dtw_ctrl.sv
module dtw_ctrl
  import dtw_pkg::*;
(
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output strobe_t           stb
);
  logic [WORD_W-1:0] word;
  logic inChan, bankOk, isTctl, isTdrv, isId, wrAccess, rdAccess;

  assign word = paddr[ADDR_W-1:2];

  always_comb begin
    inChan   = (paddr[ADDR_W-1:6] == '0);
    bankOk   = inChan && (bank_reg_e'(paddr[4:2]) != REG_NONE);
    isTctl   = (word == TCTL_WORD);
    isTdrv   = (word == TDRV_WORD);
    isId     = (word >= ID_FIRST_WORD);
    wrAccess = psel && penable && pwrite;
    rdAccess = psel && !pwrite;

    stb         = '0;
    stb.chanIdx = paddr[5];
    stb.bankReg = bank_reg_e'(paddr[4:2]);
    stb.idIdx   = ID_IDX_W'(word - ID_FIRST_WORD);
    stb.chanWr  = wrAccess && bankOk;
    stb.tctlWr  = wrAccess && isTctl;
    stb.tdrvWr  = wrAccess && isTdrv;
    stb.rdSrc   = RD_NONE;
    if (rdAccess) begin
      if (bankOk)      stb.rdSrc = RD_CHAN;
      else if (isTctl) stb.rdSrc = RD_TCTL;
      else if (isId)   stb.rdSrc = RD_ID;
    end
  end
endmodule

// File: rtl/dtw_chan.sv
module dtw_chan
  import dtw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  bank_reg_e         regSel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irqMasked
);
  logic [DATA_W-1:0] loadQ, valueQ;
  logic [CTL_W-1:0]  ctlQ;
  logic              rawQ;
  logic              running;

  assign running   = ctlQ[CTL_EN] && !(ctlQ[CTL_ONE] && valueQ == '0);
  assign irqMasked = rawQ && ctlQ[CTL_IEN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ  <= '0;
      valueQ <= '1;
      ctlQ   <= CTL_RESET;
      rawQ   <= 1'b0;
    end else begin
      if (running) begin
        if (valueQ != '0) begin
          valueQ <= valueQ - 1'b1;
          if (valueQ == DATA_W'(1)) rawQ <= 1'b1;
        end else begin
          valueQ <= ctlQ[CTL_PER] ? loadQ : '1;
        end
      end
      if (wrEn) begin
        case (regSel)
          REG_LOAD: begin loadQ <= wdata; valueQ <= wdata; end
          REG_BGLD: loadQ <= wdata;
          REG_CTRL: ctlQ <= wdata[CTL_W-1:0] & CTL_MASK;
          REG_ICLR: rawQ <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regSel)
      REG_LOAD, REG_BGLD: rdata = loadQ;
      REG_VALUE:          rdata = valueQ;
      REG_CTRL:           rdata = DATA_W'(ctlQ);
      REG_RAW:            rdata = DATA_W'(rawQ);
      REG_MSK:            rdata = DATA_W'(irqMasked);
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtw_dp.sv
module dtw_dp
  import dtw_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [CH_COUNT-1:0] irqCh,
  output logic                irqAny,
  output logic                testEn,
  output logic [CH_COUNT-1:0] testBits
);
  logic [DATA_W-1:0]   chanRd [CH_COUNT];
  logic [CH_COUNT-1:0] chanIrq;

  for (genvar i = 0; i < CH_COUNT; i++) begin : g_chan
    dtw_chan u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .wrEn     (stb.chanWr && (int'(stb.chanIdx) == i)),
      .regSel   (stb.bankReg),
      .wdata    (wdata),
      .rdata    (chanRd[i]),
      .irqMasked(chanIrq[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testEn   <= 1'b0;
      testBits <= '0;
    end else begin
      if (stb.tctlWr) testEn   <= wdata[0];
      if (stb.tdrvWr) testBits <= wdata[CH_COUNT-1:0];
    end
  end

  assign irqCh  = testEn ? testBits : chanIrq;
  assign irqAny = |irqCh;

  always_comb begin
    case (stb.rdSrc)
      RD_CHAN: rdata = chanRd[stb.chanIdx];
      RD_TCTL: rdata = DATA_W'(testEn);
      RD_ID:   rdata = DATA_W'(idByte(stb.idIdx));
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_timer_apb.sv
module dual_timer_apb
  import dtw_pkg::*;
(
  input  logic                pclk,
  input  logic                presetn,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  output logic [DATA_W-1:0]   prdata,
  output logic                pready,
  output logic                pslverr,
  output logic [CH_COUNT-1:0] irqCh,
  output logic                irqAny
);
  strobe_t             stb;
  logic                testEn;
  logic [CH_COUNT-1:0] testBits;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  dtw_ctrl u_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .stb(stb)
  );

  dtw_dp u_dp (
    .clk(pclk), .rstN(presetn), .stb(stb), .wdata(pwdata), .rdata(prdata),
    .irqCh(irqCh), .irqAny(irqAny), .testEn(testEn), .testBits(testBits)
  );
endmodule

// File: rtl/dual_timer_apb_chk.sv
module dual_timer_apb_chk
  import dtw_pkg::*;
(
  input logic                pclk,
  input logic                presetn,
  input logic                psel,
  input logic                penable,
  input logic                pwrite,
  input logic [ADDR_W-1:0]   paddr,
  input logic [DATA_W-1:0]   pwdata,
  input logic [DATA_W-1:0]   prdata,
  input logic [CH_COUNT-1:0] irqCh,
  input logic                irqAny,
  input logic                testEn,
  input logic [CH_COUNT-1:0] testBits
);
  logic wrAcc, mapped;
  assign wrAcc  = psel && penable && pwrite;
  assign mapped = (paddr[11:6] == 6'd0 && paddr[4:2] != 3'd7) ||
                  (paddr[11:2] == 10'h3C0) || (paddr[11:2] >= 10'h3F4);

  AST_TCTL_CAPTURE: assert property (@(posedge pclk) disable iff (!presetn)
    (wrAcc && paddr == 12'hF00) |=> testEn == $past(pwdata[0])); // R2
  AST_TDRV_CAPTURE: assert property (@(posedge pclk) disable iff (!presetn)
    (wrAcc && paddr == 12'hF04) |=> testBits == $past(pwdata[1:0])); // R3
  AST_TEST_OVERRIDE: assert property (@(posedge pclk) disable iff (!presetn)
    testEn |-> irqCh == testBits); // R4
  AST_ANY_IS_OR: assert property (@(posedge pclk) disable iff (!presetn)
    irqAny == (|irqCh)); // R5
  AST_ID_FIRST: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr == 12'hFD0) |-> prdata == 32'h04); // R6
  AST_UNMAPPED_READ: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && !mapped) |-> prdata == '0); // R7
  AST_NO_ACCESS_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    !wrAcc |=> $stable(testEn) && $stable(testBits)); // R8
endmodule

bind dual_timer_apb dual_timer_apb_chk u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
  .irqCh(irqCh), .irqAny(irqAny), .testEn(testEn), .testBits(testBits)
);

// File: tb/dual_timer_apb_bench.sv
module dual_timer_apb_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irqAny;
  logic [1:0]  irqCh;
  int total = 0, bad = 0;
  logic lastReady, lastErr;

  always #4 clk = ~clk;

  dual_timer_apb u_dual_timer_apb (
    .pclk(clk), .presetn(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irqCh(irqCh), .irqAny(irqAny)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1; d = prdata; lastReady = pready; lastErr = pslverr;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rdChk(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    apbRead(a, v);
    chk(req, v, exp);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R4 irqCh reset", 32'(irqCh), 0);
    chk("R5 irqAny reset", 32'(irqAny), 0);
    rdChk(12'hF00, 0, "R2 test-control reset");
    rdChk(12'h008, 32'h20, "R9 ch0 control");
    rdChk(12'h028, 32'h20, "R9 ch1 control");
    rdChk(12'h004, 32'hFFFFFFFF, "R9 ch0 value");
    rdChk(12'h000, 0, "R9 ch0 load");
    rdChk(12'h030, 0, "R9 ch1 raw");
  endtask

  task automatic t_ids;
    logic [7:0] exp [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                             8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 12; k++) rdChk(12'hFD0 + 12'(4 * k), 32'(exp[k]), "R6 id");
  endtask

  task automatic t_tctl;
    apbWrite(12'hF00, 32'hFFFFFFFF);
    rdChk(12'hF00, 1, "R2 bit0 only");
    apbWrite(12'hF00, 0);
    rdChk(12'hF00, 0, "R2 cleared");
  endtask

  task automatic t_testmode;
    apbWrite(12'hF04, 3); #1;
    chk("R4 drive ignored when off", 32'(irqCh), 0);
    apbWrite(12'hF00, 1); #1;
    chk("R4 both driven", 32'(irqCh), 3);
    chk("R5 any", 32'(irqAny), 1);
    apbWrite(12'hF04, 1); #1;
    chk("R3 bit0 -> ch0", 32'(irqCh), 1);
    chk("R5 any one", 32'(irqAny), 1);
    apbWrite(12'hF04, 2); #1;
    chk("R3 bit1 -> ch1", 32'(irqCh), 2);
    apbWrite(12'hF04, 32'hFFFFFFFC); #1;
    chk("R3 upper ignored", 32'(irqCh), 0);
    chk("R5 any none", 32'(irqAny), 0);
    rdChk(12'hF04, 0, "R3 write-only");
    apbWrite(12'hF00, 0);
  endtask

  task automatic t_unmapped;
    rdChk(12'h01C, 0, "R7 slot7 ch0");
    rdChk(12'h03C, 0, "R7 slot7 ch1");
    rdChk(12'h040, 0, "R7 above banks");
    rdChk(12'hF08, 0, "R7 F08");
    rdChk(12'hFCC, 0, "R7 FCC");
    apbWrite(12'h040, 32'hDEAD0001);
    apbWrite(12'h060, 32'hDEAD0002);
    apbWrite(12'h01C, 32'hDEAD0003);
    apbWrite(12'h03C, 32'hDEAD0004);
    apbWrite(12'hF08, 32'hFFFFFFFF);
    rdChk(12'h000, 0, "R7 ch0 load untouched");
    rdChk(12'h020, 0, "R7 ch1 load untouched");
    rdChk(12'h008, 32'h20, "R7 ch0 control untouched");
    rdChk(12'hF00, 0, "R7 test-control untouched");
  endtask

  task automatic t_setup_only;
    @(negedge clk); psel = 1; pwrite = 1; paddr = 12'hF00; pwdata = 1; penable = 0;
    @(negedge clk); psel = 0; pwrite = 0;
    rdChk(12'hF00, 0, "R8 setup-only write");
    chk("R8 pready", 32'(lastReady), 1);
    chk("R8 pslverr", 32'(lastErr), 0);
  endtask

  task automatic t_banks;
    apbWrite(12'h000, 32'hAAAA0001);
    apbWrite(12'h020, 32'h55550002);
    rdChk(12'h000, 32'hAAAA0001, "R1 ch0 load");
    rdChk(12'h020, 32'h55550002, "R1 ch1 load");
    rdChk(12'h004, 32'hAAAA0001, "R10 load sets value");
    apbWrite(12'h018, 32'h77);
    rdChk(12'h000, 32'h77, "R10 bgload sets reload");
    rdChk(12'h018, 32'h77, "R1 bgload readback");
    rdChk(12'h004, 32'hAAAA0001, "R10 bgload keeps value");
    rdChk(12'h024, 32'h55550002, "R1 ch1 value separate");
    apbWrite(12'h008, 32'hFFFFFF1E);
    rdChk(12'h008, 32'h00, "R10 control mask low");
    apbWrite(12'h008, 32'hFFFFFFFF);
    rdChk(12'h008, 32'hE1, "R10 control mask");
    apbWrite(12'h008, 0);
  endtask

  task automatic t_oneshot;
    apbWrite(12'h028, 0);
    apbWrite(12'h020, 5);
    apbWrite(12'h028, 32'hE1);
    waitCyc(12);
    rdChk(12'h024, 0, "R11 one-shot holds zero");
    rdChk(12'h030, 1, "R11 expiry sets raw");
    rdChk(12'h034, 1, "R12 masked set");
    #1; chk("R12 irq ch1", 32'(irqCh), 2);
    chk("R5 any from ch1", 32'(irqAny), 1);
    apbWrite(12'h02C, 32'h12345678);
    rdChk(12'h030, 0, "R12 clear");
    #1; chk("R12 irq cleared", 32'(irqCh), 0);
    waitCyc(10);
    rdChk(12'h030, 0, "R11 one-shot no re-fire");
    apbWrite(12'h020, 4);
    waitCyc(10);
    apbWrite(12'h028, 32'hC1);
    rdChk(12'h030, 1, "R12 raw with ien off");
    rdChk(12'h034, 0, "R12 masked off");
    #1; chk("R12 irq masked", 32'(irqCh), 0);
    apbWrite(12'h028, 32'hE1); #1;
    chk("R4 channel drives when off", 32'(irqCh), 2);
    apbWrite(12'hF04, 0);
    apbWrite(12'hF00, 1); #1;
    chk("R4 override hides channel", 32'(irqCh), 0);
    apbWrite(12'hF00, 0); #1;
    chk("R4 channel restored", 32'(irqCh), 2);
    apbWrite(12'h02C, 0);
    apbWrite(12'h028, 0);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    apbWrite(12'h000, 3);
    apbWrite(12'h008, 32'hC0);
    waitCyc(20);
    rdChk(12'h010, 1, "R11 periodic raw");
    apbRead(12'h004, v);
    chk("R11 periodic stays within reload", 32'(v <= 3), 1);
    #1; chk("R12 ien off no irq", 32'(irqCh), 0);
    apbWrite(12'h008, 0);
    apbWrite(12'h00C, 0);
  endtask

  task automatic t_freerun;
    logic [31:0] v;
    apbWrite(12'h000, 2);
    apbWrite(12'h008, 32'h80);
    waitCyc(10);
    apbRead(12'h004, v);
    chk("R11 free-run wraps to all ones", 32'(v > 32'hF0000000), 1);
    apbWrite(12'h008, 0);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    t_reset();
    t_ids();
    t_tctl();
    t_testmode();
    t_unmapped();
    t_setup_only();
    t_banks();
    t_oneshot();
    t_periodic();
    t_freerun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule